// File: doc/BRIEF.md
# Indirect Shadow Register Bank

This block puts a small set of 10-bit shadow registers behind one management register address. Each 16-bit write to that address carries a commit flag in bit 15 and a shadow selector in bits [14:10]. When the commit flag is set, the low ten bits go into the selected shadow. When it is clear, no shadow changes and the write only chooses which shadow the next read will return.

Two shadows are implemented. The first holds the autodetect mode enable, with a read-only fault status bit. Its reset value comes from two strap pins. The second holds four LED disable bits. A read returns the contents of the currently latched shadow and echoes the selector, so software can see which shadow it is looking at.

Top module: `shreg_bank`

## Requirements
- R1: While rst_n is low and after reset, the latched selector is 5'b11000, `mode_auto` equals `strap_a & strap_b`, and `led_off` is 4'b0000.
- R2: An addressed write with bit 15 = 1 and bits [14:10] = 5'b11000 loads bit 0 into `mode_auto`, and the value is visible after the next rising clock edge.
- R3: An addressed write with bit 15 = 0 changes no shadow contents. It latches bits [14:10], and later reads return bit 15 = 0, bits [14:10] = that selector, and bits [9:0] = that shadow's contents.
- R4: An addressed write with bit 15 = 1 also latches its selector, so the next read returns the shadow just written.
- R5: In the autodetect shadow, bits [8:1] always read 0, whatever value was written to them.
- R6: In the autodetect shadow, read bit 9 equals `fault_in & mode_auto` in the same cycle as the read.
- R7: Selector 5'b00110 addresses the LED shadow. Bits [3:0] of a committed write drive `led_off` (1 = LED disabled). Bits [9:4] read 0.
- R8: A committed write to any other selector changes no output. A read of such a selector returns 0 in bits [9:0].
- R9: A strobe with `addr_hit` low has no effect. `rd_data` is 0 whenever `rd_en & addr_hit` is low.
- R10: When a read and a write hit in the same cycle, the read returns the selector and contents that were in place before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_a | input | 1 | Strap term for the reset value of the mode enable |
| strap_b | input | 1 | Second strap term for the reset value of the mode enable |
| addr_hit | input | 1 | The bus address matches this register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write word: commit flag, selector, body |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read word, combinational |
| fault_in | input | 1 | Status: mismatch on the received base page |
| mode_auto | output | 1 | Autodetect mode enable |
| led_off | output | 4 | LED disable bits |

## Verification
A read and a write can both hit the address in one clock cycle. The write updates the selector and a shadow at the edge, while the read word is formed from the state before that edge. The bench drives a committed LED write that moves the selector, together with a read, in one low clock phase. It captures `rd_data` before the edge and expects the old autodetect word. After the edge it expects the new LED value on `led_off`.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
   localparam int DEF_SEL_W  = 5;
   localparam int DEF_BODY_W = 10;
   localparam int DEF_LED_N  = 4;
   localparam logic [DEF_SEL_W-1:0] DEF_AUTO_SEL = 5'b11000;
   localparam logic [DEF_SEL_W-1:0] DEF_LED_SEL  = 5'b00110;

   typedef enum logic [1:0] {
      ACC_NONE   = 2'd0,
      ACC_SELECT = 2'd1,
      ACC_COMMIT = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/shreg_decode.sv
module shreg_decode
   import shreg_pkg::*;
#(
   parameter int SEL_W  = DEF_SEL_W,
   parameter int BODY_W = DEF_BODY_W,
   parameter logic [SEL_W-1:0] RST_SEL = DEF_AUTO_SEL,
   localparam int WORD_W = 1 + SEL_W + BODY_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              addr_hit,
   input  logic [WORD_W-1:0] wr_data,
   output acc_kind_e         kind,
   output logic [SEL_W-1:0]  wr_sel,
   output logic [BODY_W-1:0] wr_body,
   output logic [SEL_W-1:0]  sel_q
);
   assign wr_sel  = wr_data[WORD_W-2 -: SEL_W];
   assign wr_body = wr_data[BODY_W-1:0];

   always_comb begin
      if (!(wr_en && addr_hit))     kind = ACC_NONE;
      else if (wr_data[WORD_W-1])   kind = ACC_COMMIT;
      else                          kind = ACC_SELECT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                sel_q <= RST_SEL;
      else if (kind != ACC_NONE) sel_q <= wr_sel;
   end
endmodule

// File: rtl/shreg_field.sv
module shreg_field #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] rst_val,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= rst_val;
      else if (load) q <= din;
   end
endmodule

// File: rtl/shreg_bank.sv
module shreg_bank
   import shreg_pkg::*;
#(
   parameter int SEL_W   = DEF_SEL_W,
   parameter int BODY_W  = DEF_BODY_W,
   parameter int LED_N   = DEF_LED_N,
   parameter bit HAS_LED = 1'b1,
   parameter logic [SEL_W-1:0] AUTO_SEL = DEF_AUTO_SEL,
   parameter logic [SEL_W-1:0] LED_SEL  = DEF_LED_SEL,
   localparam int WORD_W = 1 + SEL_W + BODY_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_a,
   input  logic              strap_b,
   input  logic              addr_hit,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   input  logic              fault_in,
   output logic              mode_auto,
   output logic [LED_N-1:0]  led_off
);
   generate
      if (BODY_W < 2)         begin : g_bad_body $error("BODY_W must be at least 2"); end
      if (LED_N > BODY_W)     begin : g_bad_led  $error("LED_N exceeds BODY_W"); end
      if (HAS_LED && LED_SEL == AUTO_SEL)
                              begin : g_bad_sel  $error("selectors collide"); end
   endgenerate

   acc_kind_e         kind;
   logic [SEL_W-1:0]  wr_sel, sel_q;
   logic [BODY_W-1:0] wr_body, rd_body;
   logic              auto_load;
   logic              unused_body_bits;

   shreg_decode #(.SEL_W(SEL_W), .BODY_W(BODY_W), .RST_SEL(AUTO_SEL)) u_dec (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_hit(addr_hit),
      .wr_data(wr_data), .kind(kind), .wr_sel(wr_sel), .wr_body(wr_body),
      .sel_q(sel_q)
   );

   assign auto_load = (kind == ACC_COMMIT) && (wr_sel == AUTO_SEL);

   shreg_field #(.W(1)) u_auto (
      .clk(clk), .rst_n(rst_n), .rst_val(strap_a & strap_b),
      .load(auto_load), .din(wr_body[0]), .q(mode_auto)
   );

   logic [BODY_W-1:0] auto_word, led_word;
   assign auto_word = {fault_in & mode_auto, {(BODY_W-2){1'b0}}, mode_auto};

   generate
      if (HAS_LED) begin : g_led
         logic led_load;
         assign led_load = (kind == ACC_COMMIT) && (wr_sel == LED_SEL);
         shreg_field #(.W(LED_N)) u_led (
            .clk(clk), .rst_n(rst_n), .rst_val({LED_N{1'b0}}),
            .load(led_load), .din(wr_body[LED_N-1:0]), .q(led_off)
         );
         if (LED_N < BODY_W) begin : g_pad
            assign led_word = {{(BODY_W-LED_N){1'b0}}, led_off};
         end else begin : g_full
            assign led_word = led_off;
         end
      end else begin : g_no_led
         assign led_off  = {LED_N{1'b0}};
         assign led_word = {BODY_W{1'b0}};
      end
   endgenerate

   assign unused_body_bits = ^wr_body;

   always_comb begin
      if (sel_q == AUTO_SEL)                rd_body = auto_word;
      else if (HAS_LED && sel_q == LED_SEL) rd_body = led_word;
      else                                  rd_body = '0;
   end

   assign rd_data = (rd_en && addr_hit) ? {1'b0, sel_q, rd_body} : '0;
endmodule

// File: rtl/shreg_bank_chk.sv
module shreg_bank_chk #(
   parameter int SEL_W  = 5,
   parameter int BODY_W = 10,
   parameter int LED_N  = 4,
   parameter logic [SEL_W-1:0] AUTO_SEL = 5'b11000,
   localparam int WORD_W = 1 + SEL_W + BODY_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr_hit,
   input logic              wr_en,
   input logic [WORD_W-1:0] wr_data,
   input logic              rd_en,
   input logic [WORD_W-1:0] rd_data,
   input logic              fault_in,
   input logic              mode_auto,
   input logic [LED_N-1:0]  led_off
);
   logic rd_hit, wr_hit, auto_rd;
   assign rd_hit  = rd_en && addr_hit;
   assign wr_hit  = wr_en && addr_hit;
   assign auto_rd = rd_hit && (rd_data[WORD_W-2 -: SEL_W] == AUTO_SEL);

   p_commit_auto_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wr_data[WORD_W-1] && wr_data[WORD_W-2 -: SEL_W] == AUTO_SEL)
      |=> (mode_auto == $past(wr_data[0])));

   p_select_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !wr_data[WORD_W-1]) |=> ($stable(mode_auto) && $stable(led_off)));

   p_rd_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |-> !rd_data[WORD_W-1]);

   p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      auto_rd |-> (rd_data[BODY_W-2:1] == '0));

   p_fault_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      auto_rd |-> (rd_data[BODY_W-1] == (fault_in && mode_auto)));

   p_no_hit_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> ($stable(mode_auto) && $stable(led_off)));

   p_idle_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |-> (rd_data == '0));
endmodule

bind shreg_bank shreg_bank_chk #(
   .SEL_W(SEL_W), .BODY_W(BODY_W), .LED_N(LED_N), .AUTO_SEL(AUTO_SEL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr_hit(addr_hit), .wr_en(wr_en),
   .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .fault_in(fault_in),
   .mode_auto(mode_auto), .led_off(led_off)
);

// File: tb/tb_shreg_bank.sv
module tb_shreg_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_a = 1'b1, strap_b = 1'b1;
   logic        addr_hit = 1'b0, wr_en = 1'b0, rd_en = 1'b0, fault_in = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        mode_auto;
   logic [3:0]  led_off;
   int          errors = 0, checks = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   shreg_bank dut (
      .clk(clk), .rst_n(rst_n), .strap_a(strap_a), .strap_b(strap_b),
      .addr_hit(addr_hit), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .fault_in(fault_in), .mode_auto(mode_auto),
      .led_off(led_off)
   );

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One bus cycle: drive in the low phase, capture the read, pass one edge.
   task automatic access(input logic we, input logic [15:0] wd, input logic re,
                         input logic hit, output logic [15:0] rv);
      @(negedge clk);
      wr_en = we; wr_data = wd; rd_en = re; addr_hit = hit;
      #1 rv = rd_data;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; addr_hit = 1'b0; wr_data = '0;
   endtask

   task automatic rd(output logic [15:0] rv);
      access(1'b0, 16'h0, 1'b1, 1'b1, rv);
   endtask

   task automatic wr(input logic [15:0] wd);
      logic [15:0] dummy;
      access(1'b1, wd, 1'b0, 1'b1, dummy);
   endtask

   task automatic do_reset(input logic a, input logic b);
      @(negedge clk);
      strap_a = a; strap_b = b; rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_r1;
      logic [15:0] v;
      do_reset(1'b1, 1'b1);
      check("R1 mode_auto", {15'd0, mode_auto}, 16'd1);
      check("R1 led_off", {12'd0, led_off}, 16'd0);
      rd(v);
      check("R1 reset read", v, 16'h6001);
      do_reset(1'b0, 1'b1);
      check("R1 strap and", {15'd0, mode_auto}, 16'd0);
      do_reset(1'b1, 1'b1);
   endtask

   task automatic t_select_r3;
      logic [15:0] v;
      wr(16'h1BFF);                               // select LED shadow, no commit
      check("R3 led unchanged", {12'd0, led_off}, 16'd0);
      check("R3 auto unchanged", {15'd0, mode_auto}, 16'd1);
      rd(v);
      check("R3 read echo", v, 16'h1800);
   endtask

   task automatic t_led_r7_r4;
      logic [15:0] v;
      wr(16'h6000);                               // move selector away
      wr(16'h9BF5);                               // commit LED, body 3F5
      check("R7 led_off", {12'd0, led_off}, 16'h0005);
      rd(v);
      check("R4 R7 read after commit", v, 16'h1805);
   endtask

   task automatic t_auto_r2_r5_r6;
      logic [15:0] v;
      wr(16'hE3FE);                               // commit auto, bit0 = 0
      check("R2 clear", {15'd0, mode_auto}, 16'd0);
      fault_in = 1'b1;
      rd(v);
      check("R5 R6 fault masked", v, 16'h6000);
      wr(16'hE1FF);                               // commit auto, bit0 = 1
      check("R2 set", {15'd0, mode_auto}, 16'd1);
      rd(v);
      check("R5 R6 fault shown", v, 16'h6201);
      fault_in = 1'b0;
      rd(v);
      check("R6 fault low", v, 16'h6001);
   endtask

   task automatic t_unimpl_r8;
      logic [15:0] v;
      wr(16'h97FF);                               // commit to selector 00101
      check("R8 auto kept", {15'd0, mode_auto}, 16'd1);
      check("R8 led kept", {12'd0, led_off}, 16'h0005);
      rd(v);
      check("R8 read zero body", v, 16'h1400);
   endtask

   task automatic t_no_hit_r9;
      logic [15:0] v;
      wr(16'hE001);                               // back to auto selector
      access(1'b1, 16'hE000, 1'b0, 1'b0, v);      // no address match
      check("R9 write ignored", {15'd0, mode_auto}, 16'd1);
      access(1'b0, 16'h0, 1'b1, 1'b0, v);
      check("R9 read without hit", v, 16'h0000);
      access(1'b0, 16'h0, 1'b0, 1'b1, v);
      check("R9 no read strobe", v, 16'h0000);
   endtask

   task automatic t_same_cycle_r10;
      logic [15:0] v;
      access(1'b1, 16'h980A, 1'b1, 1'b1, v);      // LED commit + read together
      check("R10 read sees old state", v, 16'h6001);
      check("R10 write landed", {12'd0, led_off}, 16'h000A);
      rd(v);
      check("R10 following read", v, 16'h180A);
   endtask

   initial begin
      t_reset_r1();
      t_select_r3();
      t_led_r7_r4();
      t_auto_r2_r5_r6();
      t_unimpl_r8();
      t_no_hit_r9();
      t_same_cycle_r10();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule